// File: doc/BRIEF.md
# Debounced GPIO register block

This block is a small memory-mapped input/output peripheral. A host reaches it through a plain register bus made of a byte address, a write strobe, write data and combinational read data. Every register is 32 bits wide. The host can light eight LEDs and read fourteen front-panel inputs: a five-way joystick, a push button and eight DIP switches. It can also drive and sample two general-purpose header ports.

Every pin that enters the block first passes through a two-flop synchroniser. The synchronised panel inputs are readable directly. They are also readable as a debounced view, in which a bit takes a new level only after that level has held for a number of clock cycles set by software. One threshold register governs all bits. Each input bit has its own counter.

Each header port has two registers. The output latch is written through a per-port write mask, so that only the bits selected by the mask change. A read of the data register returns the synchronised pin levels, not the latch contents.

Top module: `iopad_ctrl`

## Requirements
- R1: After reset, every register reads 0, the LED outputs are 0 and both header output latches are 0.
- R2: A write to byte offset 0x00 sets `led_o` to write-data bits 7:0 one cycle later (1 = LED on). A read of 0x00 returns those eight bits with bits 31:8 reading zero.
- R3: A read of offset 0x04 returns the panel inputs two clock edges after they change at the pins. The bit layout is bits 13:9 for the joystick (left, down, up, right, press), bit 8 for the button and bits 7:0 for the DIP switches.
- R4: A read of offset 0x08 returns the debounced inputs in the same layout as offset 0x04. A synchronised bit that differs from its debounced value for T+1 consecutive edges, where T is the threshold, is copied into the debounced value on that edge.
- R5: A synchronised input excursion that lasts T edges or fewer leaves the debounced bit unchanged. The per-bit count restarts whenever the synchronised bit equals the debounced bit.
- R6: With a threshold of 0, the debounced bit takes the synchronised level on the first edge at which the two differ.
- R7: Offset 0x0C holds the threshold as a full 32-bit value that reads back exactly as written.
- R8: A write to offset 0x10 (header A) or 0x18 (header B) changes only the output-latch bits whose bit in the port mask (offset 0x14 or 0x1C) is 1. All other latch bits keep their value.
- R9: A read of offset 0x10 or 0x18 returns the synchronised header pin levels, two edges after they change, rather than the output latch.
- R10: Header A uses bits 24:0 and header B uses bits 13:0. Write data beyond a port's width is dropped, and mask and data reads return zero above that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 5 | Byte address; bits 4:2 select the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| led_o | output | 8 | LED drive, 1 = on |
| panel_i | input | 14 | Joystick, button and DIP switch pins |
| hdr_a_i | input | 25 | Header A pin levels |
| hdr_a_o | output | 25 | Header A output latch |
| hdr_b_i | input | 14 | Header B pin levels |
| hdr_b_o | output | 14 | Header B output latch |

## Verification
The debounce path is exercised with four kinds of input:
- A step held well beyond the threshold, which has to appear after exactly T+1 edges.
- A pulse exactly T edges long, which separates a correct `>=` comparison from an off-by-one.
- A threshold of 0, which separates next-cycle following from a counter that always waits at least one cycle.
- Chattering patterns, which show whether the count restarts when the input returns.

The header ports are tried with three write patterns:
- Overlapping masks, where only a mask-respecting latch gives the expected mix.
- An all-ones mask.
- Pin levels that differ from the latch, which tells a read of the pins apart from a read-back of the latch.

// File: rtl/iopad_pkg.sv
package iopad_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;
  localparam int IDX_LSB = 2;

  typedef enum logic [2:0] {
    RI_LED    = 3'd0,
    RI_RAW    = 3'd1,
    RI_DEB    = 3'd2,
    RI_THR    = 3'd3,
    RI_HA_DAT = 3'd4,
    RI_HA_MSK = 3'd5,
    RI_HB_DAT = 3'd6,
    RI_HB_MSK = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/iopad_sync.sv
module iopad_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/iopad_debounce.sv
module iopad_debounce #(
  parameter int W     = 14,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     in_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [W-1:0]     deb_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             deb_q, deb_d;

    always_comb begin
      cnt_d = cnt_q;
      deb_d = deb_q;
      if (in_i[gi] != deb_q) begin
        if (cnt_q >= thr_i) begin
          deb_d = in_i[gi];
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        deb_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        deb_q <= deb_d;
      end
    end

    assign deb_o[gi] = deb_q;

    // R5: agreement between input and debounced bit keeps the bit still
    a_r5_agree_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_i[gi] == deb_o[gi]) |=> (deb_o[gi] == $past(deb_o[gi])));

    // R6: zero threshold follows on the next edge
    a_r6_zero_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((thr_i == '0) && (in_i[gi] != deb_o[gi])) |=> (deb_o[gi] == $past(in_i[gi])));
  end
endmodule

// File: rtl/iopad_hdr.sv
module iopad_hdr #(
  parameter int W = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dat_we_i,
  input  logic         msk_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] msk_o,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] out_q, out_d;
  logic [W-1:0] msk_q, msk_d;

  iopad_sync #(.W(W)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_o)
  );

  always_comb begin
    out_d = out_q;
    msk_d = msk_q;
    if (dat_we_i) out_d = (out_q & ~msk_q) | (wdata_i & msk_q);
    if (msk_we_i) msk_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      msk_q <= '0;
    end else begin
      out_q <= out_d;
      msk_q <= msk_d;
    end
  end

  assign out_o = out_q;
  assign msk_o = msk_q;

  // R8: bits outside the mask are kept across a data write
  a_r8_mask_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i |=> (((out_o ^ $past(out_o)) & ~$past(msk_o)) == '0));

  // R8: bits inside the mask take the written value
  a_r8_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i |=> ((out_o & $past(msk_o)) == ($past(wdata_i) & $past(msk_o))));
endmodule

// File: rtl/iopad_ctrl.sv
module iopad_ctrl
  import iopad_pkg::*;
#(
  parameter int LED_W = 8,
  parameter int IN_W  = 14,
  parameter int HA_W  = 25,
  parameter int HB_W  = 14,
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [LED_W-1:0]  led_o,
  input  logic [IN_W-1:0]   panel_i,
  input  logic [HA_W-1:0]   hdr_a_i,
  output logic [HA_W-1:0]   hdr_a_o,
  input  logic [HB_W-1:0]   hdr_b_i,
  output logic [HB_W-1:0]   hdr_b_o
);
  localparam int IDX_W = 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // decode
  reg_idx_e idx;
  logic     unused_addr;
  assign idx         = reg_idx_e'(bus_addr_i[IDX_LSB +: IDX_W]);
  assign unused_addr = ^bus_addr_i[IDX_LSB-1:0];

  logic we_led, we_thr, we_ha_dat, we_ha_msk, we_hb_dat, we_hb_msk;
  assign we_led    = bus_we_i && (idx == RI_LED);
  assign we_thr    = bus_we_i && (idx == RI_THR);
  assign we_ha_dat = bus_we_i && (idx == RI_HA_DAT);
  assign we_ha_msk = bus_we_i && (idx == RI_HA_MSK);
  assign we_hb_dat = bus_we_i && (idx == RI_HB_DAT);
  assign we_hb_msk = bus_we_i && (idx == RI_HB_MSK);

  // LED and threshold registers
  logic [LED_W-1:0] led_q, led_d;
  logic [CNT_W-1:0] thr_q, thr_d;

  always_comb begin
    led_d = led_q;
    thr_d = thr_q;
    if (we_led) led_d = bus_wdata_i[LED_W-1:0];
    if (we_thr) thr_d = bus_wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= '0;
      thr_q <= '0;
    end else begin
      led_q <= led_d;
      thr_q <= thr_d;
    end
  end
  assign led_o = led_q;

  // panel inputs
  logic [IN_W-1:0] raw_sync, deb_val;

  iopad_sync #(.W(IN_W)) u_panel_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (panel_i),
    .q_o   (raw_sync)
  );

  iopad_debounce #(.W(IN_W), .CNT_W(CNT_W)) u_debounce (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .in_i  (raw_sync),
    .thr_i (thr_q),
    .deb_o (deb_val)
  );

  // header ports
  logic [HA_W-1:0] ha_msk, ha_pin;
  logic [HB_W-1:0] hb_msk, hb_pin;

  iopad_hdr #(.W(HA_W)) u_hdr_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .dat_we_i(we_ha_dat),
    .msk_we_i(we_ha_msk),
    .wdata_i (bus_wdata_i[HA_W-1:0]),
    .pin_i   (hdr_a_i),
    .out_o   (hdr_a_o),
    .msk_o   (ha_msk),
    .pin_o   (ha_pin)
  );

  iopad_hdr #(.W(HB_W)) u_hdr_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .dat_we_i(we_hb_dat),
    .msk_we_i(we_hb_msk),
    .wdata_i (bus_wdata_i[HB_W-1:0]),
    .pin_i   (hdr_b_i),
    .out_o   (hdr_b_o),
    .msk_o   (hb_msk),
    .pin_o   (hb_pin)
  );

  // read mux
  always_comb begin
    unique case (idx)
      RI_LED:    bus_rdata_o = REG_W'(led_q);
      RI_RAW:    bus_rdata_o = REG_W'(raw_sync);
      RI_DEB:    bus_rdata_o = REG_W'(deb_val);
      RI_THR:    bus_rdata_o = REG_W'(thr_q);
      RI_HA_DAT: bus_rdata_o = REG_W'(ha_pin);
      RI_HA_MSK: bus_rdata_o = REG_W'(ha_msk);
      RI_HB_DAT: bus_rdata_o = REG_W'(hb_pin);
      RI_HB_MSK: bus_rdata_o = REG_W'(hb_msk);
      default:   bus_rdata_o = '0;
    endcase
  end

  // R2: LED write lands on the pins one edge later
  a_r2_led_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    we_led |=> (led_o == $past(bus_wdata_i[LED_W-1:0])));

  // R7: threshold reads back exactly as written
  a_r7_thr_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    we_thr |=> ((idx != RI_THR) || (bus_rdata_o == $past(bus_wdata_i))));

  // R10: header B mask read is zero above its width
  a_r10_hb_width: assert property (@(posedge clk_i) disable iff (!rst_n)
    (idx == RI_HB_MSK) |-> ((bus_rdata_o >> HB_W) == '0));
endmodule

// File: tb/iopad_ctrl_tb.sv
module iopad_ctrl_tb;
  localparam int IN_W = 14;
  localparam int HA_W = 25;
  localparam int HB_W = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  led;
  logic [IN_W-1:0] panel = '0;
  logic [HA_W-1:0] ha_in = '0, ha_out;
  logic [HB_W-1:0] hb_in = '0, hb_out;

  int checks = 0;
  int fails = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iopad_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_addr_i (addr),
    .bus_we_i   (we),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .led_o      (led),
    .panel_i    (panel),
    .hdr_a_i    (ha_in),
    .hdr_a_o    (ha_out),
    .hdr_b_i    (hb_in),
    .hdr_b_o    (hb_out)
  );

  // behavioural reference model
  logic [IN_W-1:0] m_s1, m_s2, m_deb;
  int unsigned     m_cnt [IN_W];
  logic [31:0]     m_thr;
  logic [7:0]      m_led;
  logic [HA_W-1:0] m_ha_out, m_ha_msk, m_ha_s1, m_ha_s2;
  logic [HB_W-1:0] m_hb_out, m_hb_msk, m_hb_s1, m_hb_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_deb = '0; m_thr = '0; m_led = '0;
      m_ha_out = '0; m_ha_msk = '0; m_ha_s1 = '0; m_ha_s2 = '0;
      m_hb_out = '0; m_hb_msk = '0; m_hb_s1 = '0; m_hb_s2 = '0;
      for (int b = 0; b < IN_W; b++) m_cnt[b] = 0;
    end else begin
      for (int b = 0; b < IN_W; b++) begin
        if (m_s2[b] != m_deb[b]) begin
          if (m_cnt[b] >= m_thr) begin
            m_deb[b] = m_s2[b];
            m_cnt[b] = 0;
          end else m_cnt[b] = m_cnt[b] + 1;
        end else m_cnt[b] = 0;
      end
      m_s2 = m_s1; m_s1 = panel;
      m_ha_s2 = m_ha_s1; m_ha_s1 = ha_in;
      m_hb_s2 = m_hb_s1; m_hb_s1 = hb_in;
      if (we) begin
        case (addr[4:2])
          3'd0: m_led = wdata[7:0];
          3'd3: m_thr = wdata;
          3'd4: m_ha_out = (m_ha_out & ~m_ha_msk) | (wdata[HA_W-1:0] & m_ha_msk);
          3'd5: m_ha_msk = wdata[HA_W-1:0];
          3'd6: m_hb_out = (m_hb_out & ~m_hb_msk) | (wdata[HB_W-1:0] & m_hb_msk);
          3'd7: m_hb_msk = wdata[HB_W-1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] i);
    case (i)
      3'd0: return 32'(m_led);
      3'd1: return 32'(m_s2);
      3'd2: return 32'(m_deb);
      3'd3: return m_thr;
      3'd4: return 32'(m_ha_s2);
      3'd5: return 32'(m_ha_msk);
      3'd6: return 32'(m_hb_s2);
      default: return 32'(m_hb_msk);
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] i);
    case (i)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R7";
      3'd4, 3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns before the next rising edge
  always begin
    @(posedge clk);
    #6;
    if (model_on) begin
      chk("R2", 32'(led), 32'(m_led));
      chk("R8", 32'(ha_out), 32'(m_ha_out));
      chk("R8", 32'(hb_out), 32'(m_hb_out));
      chk(req_of(addr[4:2]), rdata, m_read(addr[4:2]));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    model_on = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 5'(a * 4), 32'h0);
    chk("R1", 32'({led, ha_out, hb_out}), 32'h0);

    // R2 LED
    wr(5'h00, 32'h0000_00A5);
    chk("R2", 32'(led), 32'hA5);
    wr(5'h00, 32'hFFF1_FF5A);
    rd("R2", 5'h00, 32'h0000_005A);
    chk("R2", 32'(led), 32'h5A);

    // R7 threshold readback
    wr(5'h0C, 32'hDEAD_BEEF);
    rd("R7", 5'h0C, 32'hDEAD_BEEF);

    // R3 raw input: two edges of synchronisation
    wr(5'h0C, 32'd3);
    rd("R3", 5'h04, 32'h0);
    panel = 14'h2A5A;
    idle(1); #1; chk("R3", rdata, 32'h0);
    idle(1); #1; chk("R3", rdata, 32'h2A5A);
    panel = 14'h0;
    idle(12);

    // R4 step with threshold 3: appears 2 + 4 edges after the pins
    rd("R4", 5'h08, 32'h0);
    panel = 14'h0100;
    idle(5); #1; chk("R4", rdata, 32'h0);
    idle(1); #1; chk("R4", rdata, 32'h0100);

    // R5 excursion of exactly T edges is rejected
    panel = 14'h0101;
    idle(3);
    panel = 14'h0100;
    idle(10); #1; chk("R5", rdata, 32'h0100);
    // chatter: count restarts each time the input returns
    for (int r = 0; r < 5; r++) begin
      panel = 14'h3F00; idle(2);
      panel = 14'h0100; idle(2);
    end
    idle(10); #1; chk("R5", rdata, 32'h0100);

    // R6 threshold zero follows on the next edge
    wr(5'h0C, 32'd0);
    rd("R6", 5'h08, 32'h0100);
    panel = 14'h1234;
    idle(2); #1; chk("R6", rdata, 32'h0100);
    idle(1); #1; chk("R6", rdata, 32'h1234);
    panel = 14'h0;
    idle(4);

    // R8 masked header writes
    wr(5'h14, 32'h000F_0F0F);
    wr(5'h10, 32'hFFFF_FFFF);
    chk("R8", 32'(ha_out), 32'h000F_0F0F);
    wr(5'h14, 32'h0000_0F00);
    wr(5'h10, 32'h0);
    chk("R8", 32'(ha_out), 32'h000F_000F);
    wr(5'h1C, 32'h0000_3FFF);
    wr(5'h18, 32'h0000_2ABC);
    chk("R8", 32'(hb_out), 32'h2ABC);
    wr(5'h1C, 32'h0000_00FF);
    wr(5'h18, 32'h0000_1155);
    chk("R8", 32'(hb_out), 32'h2A55);

    // R9 data reads return the pins, not the latch
    ha_in = 25'h123_4567;
    hb_in = 14'h0F0F;
    idle(2);
    rd("R9", 5'h10, 32'h0123_4567);
    rd("R9", 5'h18, 32'h0000_0F0F);

    // R10 widths
    wr(5'h14, 32'hFFFF_FFFF);
    rd("R10", 5'h14, 32'h01FF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd("R10", 5'h1C, 32'h0000_3FFF);
    wr(5'h18, 32'hFFFF_0000);
    chk("R10", 32'(hb_out), 32'h0000_0000);
    ha_in = '1; hb_in = '1; panel = '1;
    idle(3);
    rd("R10", 5'h10, 32'h01FF_FFFF);
    rd("R10", 5'h18, 32'h0000_3FFF);
    rd("R10", 5'h04, 32'h0000_3FFF);

    idle(4);
    done = 1'b1;
    finish_run();
  end
endmodule